// File: doc/BRIEF.md
# Streaming Sobel Edge Detector

This block turns a raster stream of 8-bit grayscale pixels into a one-bit edge map. It accepts one pixel per clock, marked by a valid strobe, and emits one edge bit per accepted pixel. Two delay-shift row stores keep the previous two lines, so a 3×3 neighbourhood is available for every incoming pixel. Two independent pipelined filters compute the horizontal and vertical gradients side by side. A combine stage adds their absolute values and compares the sum with a threshold that is taken once per frame.

The input carries start-of-frame and end-of-line markers, and the output carries them along. Idle cycles may appear anywhere in the stream. The output is aligned with the input stream, and each output bit describes the pixel one row up and one column to the left of the pixel that produced it. Windows that would reach past the frame edge give 0. The line length is the parameter `IMG_W`. The frame height is free, because the start-of-frame marker restarts the row count.

Top module: `sobel_edge_stream`

## Requirements
- R1: Row and column are counted from the start-of-frame pixel, and each line holds `IMG_W` pixels. The output bit for the input pixel at row r and column c is the edge decision for centre (r-1, c-1), computed from the input pixels in rows r-2..r and columns c-2..c.
- R2: The horizontal gradient GH is the weighted column at c minus the weighted column at c-2, with weights 1, 2, 1 on rows r-2, r-1, r.
- R3: The vertical gradient GV is the weighted row r-2 minus the weighted row r, with weights 1, 2, 1 on columns c-2, c-1, c.
- R4: The gradients are signed 11-bit values within ±1020. The magnitude is |GH| + |GV| as an unsigned 11-bit value and never exceeds 2040.
- R5: The edge bit is 1 only when the magnitude is strictly greater than the threshold. A magnitude equal to the threshold gives 0, and a threshold of 2047 suppresses every edge.
- R6: The edge bit is 0 for every input pixel whose row is below 2 or whose column is below 2, whatever the pixel values and the threshold.
- R7: `out_valid`, `out_sof` and `out_eol` repeat `in_valid`, and the markers qualified by it, exactly 4 clock edges later. Idle input cycles and marker values during idle cycles do not change any result. `out_edge` is 0 whenever `out_valid` is 0, including after reset.
- R8: The 11-bit threshold is captured once per frame, as the start-of-frame pixel reaches the compare stage. Changes to `thresh` later in the frame have no effect on that frame's output.
- R9: A valid pixel with `in_sof` set restarts the row and column count. Frames may follow back to back, with no idle cycles, and may have any number of rows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pixel strobe |
| in_pix | input | 8 | Grayscale pixel |
| in_sof | input | 1 | First pixel of a frame |
| in_eol | input | 1 | Last pixel of a line |
| thresh | input | 11 | Magnitude threshold, captured once per frame |
| out_valid | output | 1 | Output strobe, 4 cycles after the input strobe |
| out_edge | output | 1 | Edge decision for the centre pixel |
| out_sof | output | 1 | Delayed start-of-frame marker |
| out_eol | output | 1 | Delayed end-of-line marker |

## Verification
Each input pattern isolates one part of the datapath.
- A flat image gives zero magnitude, which shows the strictness of the compare at a threshold of 0.
- Vertical and horizontal step images drive only GH or only GV. They expose a swapped kernel or a wrong sign.
- A vertical step with thresholds of 1020 and 1019 sits exactly on the compare boundary.
- Random images at a threshold of 0 separate the border rule from the datapath, and random images at a threshold of 2047 test total suppression.
- Random images with random gaps and junk markers during idle cycles test the delay line alignment and latency.
- A frame whose threshold changes mid-frame tests the once-per-frame capture.
- Short frames followed back to back test the restart of the row count.

// File: rtl/sobel_pkg.sv
package sobel_pkg;
  localparam int PIX_W  = 8;
  localparam int GRAD_W = 11;
  localparam int MAG_W  = 11;
  localparam int GRAD_MAX = 4 * ((1 << PIX_W) - 1);
  localparam int MAG_MAX  = 2 * GRAD_MAX;

  typedef logic [PIX_W-1:0]         pix_t;
  typedef logic signed [GRAD_W-1:0] grad_t;
  typedef logic [MAG_W-1:0]         mag_t;
  // window[col][row]: col 0 is the left column, row 0 is the top row
  typedef pix_t [2:0][2:0]          win_t;

  typedef struct packed {
    logic valid;
    logic sof;
    logic eol;
    logic border;
  } tag_t;

  function automatic grad_t widen(input pix_t p);
    return grad_t'({{(GRAD_W-PIX_W){1'b0}}, p});
  endfunction

  // weights 1,2,1 over three samples
  function automatic grad_t tri_sum(input pix_t a, input pix_t b, input pix_t c);
    return widen(a) + (widen(b) <<< 1) + widen(c);
  endfunction

  function automatic grad_t grad_h(input win_t w);
    return tri_sum(w[2][0], w[2][1], w[2][2]) - tri_sum(w[0][0], w[0][1], w[0][2]);
  endfunction

  function automatic grad_t grad_v(input win_t w);
    return tri_sum(w[0][0], w[1][0], w[2][0]) - tri_sum(w[0][2], w[1][2], w[2][2]);
  endfunction

  function automatic mag_t abs_sum(input grad_t a, input grad_t b);
    mag_t ua;
    mag_t ub;
    ua = a[GRAD_W-1] ? mag_t'(-a) : mag_t'(a);
    ub = b[GRAD_W-1] ? mag_t'(-b) : mag_t'(b);
    return ua + ub;
  endfunction
endpackage

// File: rtl/sobel_window.sv
module sobel_window
  import sobel_pkg::*;
#(
  parameter int IMG_W = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  pix_t pix_in,
  output win_t win
);
  localparam int N_LINES = 2;

  pix_t line_in [N_LINES];
  pix_t tap     [N_LINES];

  assign line_in[0] = pix_in;
  assign line_in[1] = tap[0];

  // one delay line per stored row; the oldest entry is the pixel one line up
  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    pix_t dly [IMG_W];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < IMG_W; i++) dly[i] <= '0;
      end else if (en) begin
        dly[0] <= line_in[g];
        for (int i = 1; i < IMG_W; i++) dly[i] <= dly[i-1];
      end
    end
    assign tap[g] = dly[IMG_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win <= '0;
    end else if (en) begin
      win[2][0] <= tap[1];
      win[2][1] <= tap[0];
      win[2][2] <= pix_in;
      win[1]    <= win[2];
      win[0]    <= win[1];
    end
  end
endmodule

// File: rtl/sobel_grad.sv
module sobel_grad
  import sobel_pkg::*;
#(
  parameter bit VERTICAL = 1'b0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  win_t  win,
  output grad_t g_q
);
  if (VERTICAL) begin : g_vert
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) g_q <= '0;
      else        g_q <= grad_v(win);
    end
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      ($signed(g_q) <= GRAD_MAX) && ($signed(g_q) >= -GRAD_MAX)); // R3
  end else begin : g_horz
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) g_q <= '0;
      else        g_q <= grad_h(win);
    end
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      ($signed(g_q) <= GRAD_MAX) && ($signed(g_q) >= -GRAD_MAX)); // R2
  end
endmodule

// File: rtl/sobel_combine.sv
module sobel_combine
  import sobel_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  grad_t gh,
  input  grad_t gv,
  input  tag_t  tag_in,
  input  mag_t  thresh,
  output logic  edge_q,
  output tag_t  tag_out
);
  mag_t mag_q;
  mag_t thr_q;
  tag_t tag_mid;
  logic thr_load;

  // the frame's threshold is taken when its first pixel reaches this stage
  assign thr_load = tag_in.valid && tag_in.sof;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mag_q   <= '0;
      thr_q   <= '0;
      tag_mid <= '0;
    end else begin
      mag_q   <= abs_sum(gh, gv);
      tag_mid <= tag_in;
      if (thr_load) thr_q <= thresh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q  <= 1'b0;
      tag_out <= '0;
    end else begin
      edge_q  <= tag_mid.valid && !tag_mid.border && (mag_q > thr_q);
      tag_out <= tag_mid;
    end
  end

  AST_MAG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    tag_mid.valid |-> (int'(mag_q) <= MAG_MAX)); // R4
  AST_THR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_q != $past(thr_q)) |-> $past(thr_load)); // R8
endmodule

// File: rtl/sobel_edge_stream.sv
module sobel_edge_stream
  import sobel_pkg::*;
#(
  parameter int IMG_W = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_pix,
  input  logic        in_sof,
  input  logic        in_eol,
  input  logic [10:0] thresh,
  output logic        out_valid,
  output logic        out_edge,
  output logic        out_sof,
  output logic        out_eol
);
  localparam logic [1:0] SAT = 2'd2;

  logic [1:0] row_q, col_q;
  logic [1:0] cur_row, cur_col;
  logic       border_now;
  tag_t       tag1, tag2, tag_end;
  win_t       win;
  grad_t      gh, gv;
  logic       edge_bit;

  // row and column of the arriving pixel, saturated at 2 (only "below 2" matters)
  assign cur_row    = in_sof ? 2'd0 : row_q;
  assign cur_col    = in_sof ? 2'd0 : col_q;
  assign border_now = (cur_row < SAT) || (cur_col < SAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
    end else if (in_valid) begin
      if (in_eol) begin
        col_q <= '0;
        row_q <= (cur_row >= SAT) ? SAT : cur_row + 2'd1;
      end else begin
        col_q <= (cur_col >= SAT) ? SAT : cur_col + 2'd1;
        row_q <= cur_row;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag1 <= '0;
      tag2 <= '0;
    end else begin
      tag1 <= '{valid: in_valid, sof: in_valid && in_sof,
                eol: in_valid && in_eol, border: border_now};
      tag2 <= tag1;
    end
  end

  sobel_window #(.IMG_W(IMG_W)) u_win (
    .clk(clk), .rst_n(rst_n), .en(in_valid), .pix_in(in_pix), .win(win)
  );

  sobel_grad #(.VERTICAL(1'b0)) u_gh (
    .clk(clk), .rst_n(rst_n), .win(win), .g_q(gh)
  );

  sobel_grad #(.VERTICAL(1'b1)) u_gv (
    .clk(clk), .rst_n(rst_n), .win(win), .g_q(gv)
  );

  sobel_combine u_cmb (
    .clk(clk), .rst_n(rst_n), .gh(gh), .gv(gv), .tag_in(tag2),
    .thresh(thresh), .edge_q(edge_bit), .tag_out(tag_end)
  );

  assign out_valid = tag_end.valid;
  assign out_sof   = tag_end.sof;
  assign out_eol   = tag_end.eol;
  assign out_edge  = edge_bit;

  AST_EDGE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_edge |-> out_valid); // R7
  AST_SOF_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sof) |-> !out_edge); // R6
endmodule

// File: tb/sim_sobel_edge_stream.sv
module sim_sobel_edge_stream;
  localparam int BW  = 10;
  localparam int LAT = 4;
  localparam int MAXR = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_pix = '0;
  logic        in_sof = 1'b0;
  logic        in_eol = 1'b0;
  logic [10:0] thresh = '0;
  logic        out_valid, out_edge, out_sof, out_eol;

  sobel_edge_stream #(.IMG_W(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
    .in_sof(in_sof), .in_eol(in_eol), .thresh(thresh),
    .out_valid(out_valid), .out_edge(out_edge), .out_sof(out_sof), .out_eol(out_eol)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0;
  int bad = 0;
  int img [0:MAXR-1][0:BW-1];

  bit    q_edge [$];
  bit    q_sof  [$];
  bit    q_eol  [$];
  int    q_stamp[$];
  string q_tag  [$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int tri3(input int a, input int b, input int c);
    return a + 2 * b + c;
  endfunction

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // edge for the centre one row up and one column left of input (r,c)
  function automatic bit exp_edge(input int r, input int c, input int thr);
    int gx, gy;
    if (r < 2 || c < 2) return 1'b0;
    gx = tri3(img[r-2][c], img[r-1][c], img[r][c])
       - tri3(img[r-2][c-2], img[r-1][c-2], img[r][c-2]);
    gy = tri3(img[r-2][c-2], img[r-2][c-1], img[r-2][c])
       - tri3(img[r][c-2], img[r][c-1], img[r][c]);
    return (iabs(gx) + iabs(gy)) > thr;
  endfunction

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_edge.size() == 0) begin
        chk(1'b0, "R7 unexpected output", 1, 0);
      end else begin
        bit e, s, l;
        int st;
        string tg;
        e = q_edge.pop_front();
        s = q_sof.pop_front();
        l = q_eol.pop_front();
        st = q_stamp.pop_front();
        tg = q_tag.pop_front();
        chk(out_edge == e, tg, int'(out_edge), int'(e));
        chk(out_sof == s, "R7 sof marker", int'(out_sof), int'(s));
        chk(out_eol == l, "R7 eol marker", int'(out_eol), int'(l));
        chk((cyc - st) == LAT, "R7 latency", cyc - st, LAT);
      end
    end
    if (rst_n && !out_valid && out_edge) chk(1'b0, "R7 edge without valid", 1, 0);
  end

  // pat: 0 flat, 1 vertical step, 2 horizontal step, 3 random, 4 low contrast
  task automatic frame(input int rows, input int thr, input int pat, input bit gaps,
                       input int glitch_at, input string tag);
    int idx = 0;
    for (int r = 0; r < rows; r++) begin
      for (int c = 0; c < BW; c++) begin
        case (pat)
          0: img[r][c] = 128;
          1: img[r][c] = (c < BW / 2) ? 0 : 255;
          2: img[r][c] = (r < rows / 2) ? 0 : 255;
          3: img[r][c] = $urandom_range(0, 255);
          default: img[r][c] = $urandom_range(100, 110);
        endcase
      end
    end
    for (int r = 0; r < rows; r++) begin
      for (int c = 0; c < BW; c++) begin
        if (gaps) begin
          int n = $urandom_range(0, 2);
          repeat (n) begin
            in_valid = 1'b0;
            in_pix   = 8'($urandom);
            in_sof   = 1'($urandom);
            in_eol   = 1'($urandom);
            @(negedge clk);
          end
        end
        in_valid = 1'b1;
        in_pix   = 8'(img[r][c]);
        in_sof   = (r == 0 && c == 0);
        in_eol   = (c == BW - 1);
        thresh   = (glitch_at > 0 && idx >= glitch_at) ? 11'(~thr) : 11'(thr);
        q_edge.push_back(exp_edge(r, c, thr));
        q_sof.push_back(r == 0 && c == 0);
        q_eol.push_back(c == BW - 1);
        q_stamp.push_back(cyc);
        q_tag.push_back(tag);
        idx++;
        @(negedge clk);
      end
    end
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    in_sof   = 1'b0;
    in_eol   = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    if (cyc > 100000) begin
      total++;
      bad++;
      $display("FAIL R7 watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R7 reset valid", int'(out_valid), 0);
    chk(out_edge == 1'b0, "R7 reset edge", int'(out_edge), 0);
    rst_n = 1'b1;
    @(negedge clk);

    frame(6, 0, 0, 1'b0, 0, "R5 flat image zero magnitude");
    idle(5);
    frame(6, 1000, 1, 1'b0, 0, "R2 vertical step");
    frame(6, 1000, 2, 1'b0, 0, "R3 horizontal step");
    idle(3);
    frame(6, 1020, 1, 1'b0, 0, "R5 magnitude equals threshold");
    frame(6, 1019, 1, 1'b0, 0, "R5 magnitude above threshold");
    frame(7, 0, 3, 1'b0, 0, "R6 border at zero threshold");
    frame(6, 2047, 3, 1'b0, 0, "R5 maximum threshold");
    for (int k = 0; k < 3; k++) frame(8, $urandom_range(300, 1500), 3, 1'b1, 0, "R7 gapped stream");
    idle(4);
    frame(6, 1500, 3, 1'b0, 10, "R8 threshold change mid-frame");
    frame(3, 100, 3, 1'b0, 0, "R9 short frame");
    frame(5, 400, 3, 1'b0, 0, "R9 back to back frame");
    for (int k = 0; k < 4; k++) frame(9, $urandom_range(100, 1200), 3, 1'b0, 0, "R1 random image");
    for (int k = 0; k < 2; k++) frame(6, $urandom_range(2, 12), 4, 1'b1, 0, "R4 low contrast");
    idle(12);
    chk(q_edge.size() == 0, "R7 all outputs delivered", q_edge.size(), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule